// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block fronts a small word-addressed memory that several requesters share. Each requester presents a request through a valid/ready handshake. A round-robin arbiter accepts at most one request per cycle. The unit serves four operations: plain load, plain store, test-and-set and compare-and-swap. Every operation returns the value the word held before the operation, together with a success bit and the ID of the requester that issued it.

The two atomic operations read the word, decide whether to write, and then perform the conditional write as one indivisible step. Once an atomic operation is accepted, the port stays closed to every requester until its write is done. Software builds a spin lock from test-and-set: it spins until the returned value is 0 and releases the lock with a plain store of 0. Compare-and-swap serves as a non-blocking update. The caller compares the returned value and the success bit with what it intended and retries on a mismatch.

Top module: `atomic_rmw_unit`

## Requirements
- R1: When the port is open, at most one `req_ready` bit is high and it goes to the first valid requester found by searching upward (wrapping) from the one after the most recently accepted requester; requester 0 is searched first after reset.
- R2: A load (op code 0) accepted on a clock edge produces a response after that same edge, carrying the word's current value and `rsp_ok` = 1.
- R3: A store (op code 1) writes `req_wdata` to the word on the accepting edge and responds after that edge with the previous value and `rsp_ok` = 1.
- R4: Test-and-set (op code 2) returns the old value; it writes 1 and reports `rsp_ok` = 1 only when the old value is 0, otherwise memory is unchanged and `rsp_ok` = 0.
- R5: A plain store of 0 to a word set by test-and-set releases it, so the next test-and-set on that word succeeds.
- R6: Compare-and-swap (op code 3) returns the old value; when the old value equals `req_cmp` it writes `req_wdata` and reports `rsp_ok` = 1, otherwise memory is unchanged and `rsp_ok` = 0.
- R7: An atomic operation's response appears two clock edges later than a plain operation's: after the third edge that counts the accepting edge as the first.
- R8: For the two cycles that follow the acceptance of an atomic operation, every `req_ready` bit is low, so no other request reaches memory between the read and the write.
- R9: Address bits 1:0 are ignored; the word index is `req_addr[ADDR_W-1:2]`.
- R10: After a synchronous reset, `rsp_valid` is low, every memory word reads 0 and the arbiter pointer is at requester 0.
- R11: `rsp_id` carries the index of the requester whose request produced the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request valid per requester |
| req_ready | output | NREQ | Request accepted this cycle, per requester |
| req_op | input | NREQ x 2 | Operation: 0 load, 1 store, 2 test-and-set, 3 compare-and-swap |
| req_addr | input | NREQ x ADDR_W | Byte address; low two bits ignored |
| req_wdata | input | NREQ x 32 | Store data, or the new value for compare-and-swap |
| req_cmp | input | NREQ x 32 | Expected value for compare-and-swap |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_id | output | ID_W | Requester that issued the answered request |
| rsp_old | output | 32 | Word value before the operation |
| rsp_ok | output | 1 | Success bit |

## Verification
The assertions assume that every request input holds a known value after reset and that the op field holds one of the four codes. They do not assume that a requester keeps `req_valid` high until it is accepted, because the arbiter and the lock must behave under any valid pattern. The stimulus drives only defined values at the falling edge. It withdraws and reissues requests freely and concentrates addresses on a handful of words with scrambled low bits. Data values are kept small, so compare-and-swap hits and misses and test-and-set contention all occur often.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_TAS   = 2'd2,
        OP_CAS   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } phase_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] data;
        logic              ok;
    } rmw_t;

    function automatic logic is_atomic(op_e op);
        return (op == OP_TAS) || (op == OP_CAS);
    endfunction

    // Decide the conditional write of an atomic operation from the old word.
    function automatic rmw_t rmw_eval(op_e op, logic [WORD_W-1:0] old,
                                      logic [WORD_W-1:0] newval,
                                      logic [WORD_W-1:0] expect_val);
        rmw_t r;
        r.we   = 1'b0;
        r.data = newval;
        r.ok   = 1'b1;
        case (op)
            OP_TAS: begin
                r.ok   = (old == '0);
                r.we   = r.ok;
                r.data = WORD_W'(1);
            end
            OP_CAS: begin
                r.ok   = (old == expect_val);
                r.we   = r.ok;
                r.data = newval;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/atom_rr_arbiter.sv
module atom_rr_arbiter #(
    parameter int N    = 3,
    parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    valid,
    input  logic            advance,
    output logic [N-1:0]    grant,
    output logic [ID_W-1:0] grant_idx,
    output logic            any
);
    logic [ID_W-1:0] ptr_q;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr_q) + k) % N;
            if (!any && valid[c]) begin
                any       = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = ID_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (grant_idx == ID_W'(N - 1)) ptr_q <= '0;
            else                           ptr_q <= grant_idx + 1'b1;
        end
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_is_valid_R1: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~valid) == '0));

endmodule

// File: rtl/atom_word_mem.sv
module atom_word_mem #(
    parameter int WORDS = 16,
    parameter int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [atom_pkg::WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]          raddr,
    output logic [atom_pkg::WORD_W-1:0] rdata
);
    logic [atom_pkg::WORD_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/atom_engine.sv
module atom_engine
    import atom_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ID_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [ID_W-1:0]   acc_id,
    input  op_e               acc_op,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [WORD_W-1:0] acc_cmp,
    output logic              idle,
    output logic [IDX_W-1:0]  mem_raddr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [WORD_W-1:0] rsp_old,
    output logic              rsp_ok
);
    phase_e            phase_q;
    logic [ID_W-1:0]   h_id;
    op_e               h_op;
    logic [IDX_W-1:0]  h_idx;
    logic [WORD_W-1:0] h_wdata;
    logic [WORD_W-1:0] h_cmp;
    logic [WORD_W-1:0] old_q;
    rmw_t              decide;

    assign idle      = (phase_q == ST_IDLE);
    assign mem_raddr = idle ? acc_idx : h_idx;
    assign decide    = rmw_eval(h_op, old_q, h_wdata, h_cmp);

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = acc_idx;
        mem_wdata = acc_wdata;
        if (idle && acc && acc_op == OP_STORE) begin
            mem_we = 1'b1;
        end else if (phase_q == ST_WRITE) begin
            mem_we    = decide.we;
            mem_waddr = h_idx;
            mem_wdata = decide.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= ST_IDLE;
            h_id      <= '0;
            h_op      <= OP_LOAD;
            h_idx     <= '0;
            h_wdata   <= '0;
            h_cmp     <= '0;
            old_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_old   <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (phase_q)
                ST_IDLE: begin
                    if (acc) begin
                        if (is_atomic(acc_op)) begin
                            h_id    <= acc_id;
                            h_op    <= acc_op;
                            h_idx   <= acc_idx;
                            h_wdata <= acc_wdata;
                            h_cmp   <= acc_cmp;
                            phase_q <= ST_READ;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_id    <= acc_id;
                            rsp_old   <= mem_rdata;
                            rsp_ok    <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    old_q   <= mem_rdata;
                    phase_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    rsp_valid <= 1'b1;
                    rsp_id    <= h_id;
                    rsp_old   <= old_q;
                    rsp_ok    <= decide.ok;
                    phase_q   <= ST_IDLE;
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    assert_plain_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && idle && !is_atomic(acc_op)) |=> rsp_valid);

    assert_atomic_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && idle && is_atomic(acc_op)) |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);

    assert_tas_keeps_word_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_WRITE && h_op == OP_TAS && old_q != '0) |-> !mem_we);

    assert_cas_swaps_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_WRITE && h_op == OP_CAS && old_q == h_cmp)
            |-> (mem_we && mem_wdata == h_wdata && mem_waddr == h_idx));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int NREQ   = 3,
    parameter int ADDR_W = 6,
    parameter int ID_W   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NREQ-1:0]                req_valid,
    output logic [NREQ-1:0]                req_ready,
    input  logic [NREQ-1:0][1:0]           req_op,
    input  logic [NREQ-1:0][ADDR_W-1:0]    req_addr,
    input  logic [NREQ-1:0][WORD_W-1:0]    req_wdata,
    input  logic [NREQ-1:0][WORD_W-1:0]    req_cmp,
    output logic                           rsp_valid,
    output logic [ID_W-1:0]                rsp_id,
    output logic [WORD_W-1:0]              rsp_old,
    output logic                           rsp_ok
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int WORDS = 1 << IDX_W;

    logic [NREQ-1:0]   grant;
    logic [ID_W-1:0]   grant_idx;
    logic              any_valid;
    logic              idle;
    logic              acc;
    op_e               sel_op;
    logic [IDX_W-1:0]  sel_idx;
    logic [WORD_W-1:0] sel_wdata;
    logic [WORD_W-1:0] sel_cmp;
    logic [IDX_W-1:0]  m_raddr;
    logic [WORD_W-1:0] m_rdata;
    logic              m_we;
    logic [IDX_W-1:0]  m_waddr;
    logic [WORD_W-1:0] m_wdata;

    atom_rr_arbiter #(.N(NREQ), .ID_W(ID_W)) u_arb (
        .clk(clk), .rst(rst), .valid(req_valid), .advance(acc),
        .grant(grant), .grant_idx(grant_idx), .any(any_valid)
    );

    assign acc       = idle && any_valid;
    assign req_ready = idle ? grant : '0;

    always_comb begin
        sel_op    = OP_LOAD;
        sel_idx   = '0;
        sel_wdata = '0;
        sel_cmp   = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) begin
                sel_op    = op_e'(req_op[i]);
                sel_idx   = req_addr[i][ADDR_W-1:2];
                sel_wdata = req_wdata[i];
                sel_cmp   = req_cmp[i];
            end
        end
    end

    atom_engine #(.IDX_W(IDX_W), .ID_W(ID_W)) u_eng (
        .clk(clk), .rst(rst), .acc(acc), .acc_id(grant_idx), .acc_op(sel_op),
        .acc_idx(sel_idx), .acc_wdata(sel_wdata), .acc_cmp(sel_cmp), .idle(idle),
        .mem_raddr(m_raddr), .mem_rdata(m_rdata), .mem_we(m_we),
        .mem_waddr(m_waddr), .mem_wdata(m_wdata), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_old(rsp_old), .rsp_ok(rsp_ok)
    );

    atom_word_mem #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst(rst), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .raddr(m_raddr), .rdata(m_rdata)
    );

    assert_port_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && is_atomic(sel_op)) |=> (req_ready == '0) ##1 (req_ready == '0));

    assert_ready_follows_valid_R1: assert property (@(posedge clk) disable iff (rst)
        ((req_ready & ~req_valid) == '0));

endmodule

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
    localparam int N     = 3;
    localparam int AW    = 6;
    localparam int IDW   = 2;
    localparam int WORDS = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]          req_valid;
    logic [N-1:0]          req_ready;
    logic [N-1:0][1:0]     req_op;
    logic [N-1:0][AW-1:0]  req_addr;
    logic [N-1:0][31:0]    req_wdata;
    logic [N-1:0][31:0]    req_cmp;
    logic                  rsp_valid;
    logic [IDW-1:0]        rsp_id;
    logic [31:0]           rsp_old;
    logic                  rsp_ok;

    atomic_rmw_unit #(.NREQ(N), .ADDR_W(AW)) u_atomic_rmw_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .rsp_old(rsp_old), .rsp_ok(rsp_ok)
    );

    int compared = 0;
    int mismatched = 0;

    // next-cycle stimulus
    logic [N-1:0]          n_valid;
    logic [N-1:0][1:0]     n_op;
    logic [N-1:0][AW-1:0]  n_addr;
    logic [N-1:0][31:0]    n_wd;
    logic [N-1:0][31:0]    n_cmp;

    // behavioural reference
    int unsigned mm [WORDS];
    int m_phase, m_ptr, h_id, h_op, h_idx;
    int unsigned h_wd, h_cmp, m_old_hold;
    bit m_rv, m_ok;
    int m_id;
    int unsigned m_old;

    task automatic check(string tag, bit cond, longint act, longint exp);
        compared++;
        if (!cond) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < WORDS; i++) mm[i] = 0;
        m_phase = 0; m_ptr = 0; m_rv = 0; m_ok = 0; m_id = 0; m_old = 0;
    endtask

    task automatic clear_next();
        n_valid = '0; n_op = '0; n_addr = '0; n_wd = '0; n_cmp = '0;
    endtask

    task automatic put(int r, int op, int addr, int unsigned wd, int unsigned cmpv);
        n_valid[r] = 1'b1;
        n_op[r]    = 2'(op);
        n_addr[r]  = AW'(addr);
        n_wd[r]    = wd;
        n_cmp[r]   = cmpv;
    endtask

    task automatic run_cycle();
        int g;
        logic [N-1:0] exp_ready;
        @(negedge clk);
        // responses reflect the edge just passed
        check("R2 R7 rsp_valid", rsp_valid == m_rv, rsp_valid, m_rv);
        if (m_rv && rsp_valid) begin
            check("R11 rsp_id", rsp_id == IDW'(m_id), rsp_id, m_id);
            check("R2 R3 R4 R6 R9 rsp_old", rsp_old == m_old, rsp_old, m_old);
            check("R4 R5 R6 rsp_ok", rsp_ok == m_ok, rsp_ok, m_ok);
        end
        req_valid = n_valid; req_op = n_op; req_addr = n_addr;
        req_wdata = n_wd; req_cmp = n_cmp;
        #1;
        g = -1;
        exp_ready = '0;
        if (m_phase == 0) begin
            for (int k = 0; k < N; k++) begin
                int c;
                c = (m_ptr + k) % N;
                if (g < 0 && n_valid[c]) g = c;
            end
            if (g >= 0) exp_ready[g] = 1'b1;
        end
        check("R1 R8 req_ready", req_ready == exp_ready, req_ready, exp_ready);
        // advance the model across the coming edge
        m_rv = 0;
        if (m_phase == 0) begin
            if (g >= 0) begin
                int idx;
                idx = int'(n_addr[g][AW-1:2]);
                m_ptr = (g + 1) % N;
                if (n_op[g] >= 2) begin
                    h_id = g; h_op = int'(n_op[g]); h_idx = idx;
                    h_wd = n_wd[g]; h_cmp = n_cmp[g];
                    m_phase = 1;
                end else begin
                    m_rv = 1; m_id = g; m_old = mm[idx]; m_ok = 1;
                    if (n_op[g] == 2'd1) mm[idx] = n_wd[g];
                end
            end
        end else if (m_phase == 1) begin
            m_old_hold = mm[h_idx];
            m_phase = 2;
        end else begin
            m_rv = 1; m_id = h_id; m_old = m_old_hold;
            if (h_op == 2) begin
                m_ok = (m_old_hold == 0);
                if (m_ok) mm[h_idx] = 1;
            end else begin
                m_ok = (m_old_hold == h_cmp);
                if (m_ok) mm[h_idx] = h_wd;
            end
            m_phase = 0;
        end
    endtask

    task automatic one_shot(int r, int op, int addr, int unsigned wd, int unsigned cmpv);
        clear_next();
        put(r, op, addr, wd, cmpv);
        run_cycle();
        clear_next();
        for (int i = 0; i < 3; i++) run_cycle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; req_cmp = '0;
        clear_next();
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state at the ports
        check("R10 rsp_valid after reset", rsp_valid == 1'b0, rsp_valid, 0);
        run_cycle();
        // R10: memory reads zero after reset
        one_shot(2, 0, 20, 0, 0);

        // R1: three loads contending, held for several cycles
        clear_next();
        put(0, 0, 4, 0, 0); put(1, 0, 5, 0, 0); put(2, 0, 7, 0, 0);
        for (int i = 0; i < 6; i++) run_cycle();

        // R3 and R9: store then load through different low address bits
        one_shot(0, 1, 8, 32'hA5A5_0001, 0);
        one_shot(1, 0, 11, 0, 0);

        // R4, R5: lock word at index 3
        one_shot(1, 2, 12, 0, 0);
        one_shot(2, 2, 13, 0, 0);
        one_shot(1, 1, 12, 0, 0);
        one_shot(2, 2, 14, 0, 0);

        // R6: hit then miss
        one_shot(0, 3, 16, 7, 0);
        one_shot(0, 3, 16, 9, 0);
        one_shot(1, 0, 16, 0, 0);
        one_shot(2, 3, 17, 11, 7);

        // R8: atomic with competing plain stores to the same word
        clear_next();
        put(0, 2, 24, 0, 0); put(1, 1, 24, 5, 0); put(2, 1, 25, 6, 0);
        for (int i = 0; i < 8; i++) run_cycle();

        // random contention on a few words
        for (int cyc = 0; cyc < 3000; cyc++) begin
            clear_next();
            for (int r = 0; r < N; r++) begin
                if ($urandom_range(0, 1) == 1)
                    put(r, int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                        $urandom_range(0, 2), $urandom_range(0, 2));
            end
            run_cycle();
        end
        clear_next();
        for (int i = 0; i < 4; i++) run_cycle();

        summary();
        $finish;
    end
endmodule